// File: doc/BRIEF.md
# Single-to-Brain-Float Rounding Converter

This block sits in a datapath that moves numbers between 32-bit IEEE single precision and the 16-bit brain-float format. The brain-float format uses a sign bit, the same 8-bit exponent with bias 127, and a 7-bit fraction. Because the exponent is unchanged, no rebias is needed. A per-beat mode input picks the direction of the conversion.

Narrowing rounds the discarded low half of the word to nearest, with ties going to even. The carry can ripple into the exponent. A NaN input never enters the rounding path. Widening is exact: the half word moves to the top and the low bits are zero-filled. Words enter and leave through valid/ready handshakes with a single register between them, so the latency is one cycle and a stalled consumer never loses a beat.

Top module: `fp_narrow_widen`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Narrowing returns the upper 16 bits (sign at bit 15, exponent at bits 14..7, fraction at bits 6..0), rounded on the dropped 16 bits. Below half truncates, above half increments, and an exact tie increments only when bit 16 of the input is 1.
- R3: When a rounding increment overflows the 7-bit fraction, the carry raises the exponent field by one (0x3FFF8000 gives 0x4000).
- R4: A finite input that rounds past the largest finite magnitude gives infinity of the same sign (exponent 0xFF, fraction 0), with `out_ovf` = 1 on that beat only.
- R5: A NaN input (exponent 0xFF, non-zero fraction) gives a quiet NaN. The sign is kept, the exponent is 0xFF, fraction bit 6 is 1, fraction bits 5..0 are input bits 21..16, and `out_ovf` = 0.
- R6: An infinite input narrows to infinity of the same sign with `out_ovf` = 0.
- R7: Subnormal inputs round by the same rule with no flushing, and may round up into the smallest normal (0x007FFFFF gives 0x0080).
- R8: Widening (`in_mode` = 1) outputs `{in_data[15:0], 16'h0000}` with `out_ovf` = 0. Input bits 31..16 have no effect in this mode.
- R9: A beat accepted on a clock edge appears on the next cycle. While `out_valid` = 1 and `out_ready` = 0, the output word and flag hold and `in_ready` is 0. Every accepted beat is delivered exactly once, in order.
- R10: In narrowing mode, `out_data[31:16]` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Producer offers a word |
| in_ready | output | 1 | Converter can take a word this cycle |
| in_mode | input | 1 | 0 = narrow single to brain-float, 1 = widen |
| in_data | input | 32 | Single-precision word, or half word in bits 15..0 when widening |
| out_valid | output | 1 | Converted word available |
| out_ready | input | 1 | Consumer takes the word this cycle |
| out_data | output | 32 | Result; the narrow result is in bits 15..0 |
| out_ovf | output | 1 | Finite value became infinity on this beat |

## Verification
Two functions can fall in the same edge. The register can release one beat and capture the next, and a beat that overflows to infinity can sit in the register while the consumer stalls. The bench provokes both by toggling `out_ready` at random while it streams mixed-mode words, including values just under the overflow boundary. It judges the result by popping an independently computed expected word and flag for every delivered beat. During a stall it also requires the held word and flag to stay unchanged, so an overflow flag that leaks into a neighbouring beat or drops during a stall shows up as a miscompare.

// File: rtl/bfc_pkg.sv
package bfc_pkg;
    localparam int WIDE_W   = 32;
    localparam int NARROW_W = 16;
    localparam int EXP_W    = 8;
    localparam int DROP_W   = WIDE_W - NARROW_W;

    typedef enum logic {
        MODE_NARROW = 1'b0,
        MODE_WIDEN  = 1'b1
    } conv_mode_e;

    typedef struct packed {
        logic              vld;
        logic [WIDE_W-1:0] word;
        logic              ovf;
    } stage_t;
endpackage

// File: rtl/bf_narrow.sv
module bf_narrow #(
    parameter int W_IN  = 32,
    parameter int W_OUT = 16,
    parameter int EXP_W = 8
) (
    input  logic [W_IN-1:0]  word_i,
    output logic [W_OUT-1:0] half_o,
    output logic             ovf_o
);
    localparam int DROP_W   = W_IN - W_OUT;
    localparam int FRAC_IN  = W_IN - 1 - EXP_W;
    localparam int FRAC_OUT = W_OUT - 1 - EXP_W;
    localparam int MAG_W    = W_OUT - 1;
    localparam logic [DROP_W:0] HALF_M1 = (DROP_W+1)'((1 << (DROP_W-1)) - 1);
    localparam logic [DROP_W:0] WRAP    = (DROP_W+1)'(1) << DROP_W;

    logic               sign_b;
    logic [EXP_W-1:0]   exp_f;
    logic [FRAC_IN-1:0] frac_f;
    logic               exp_top;
    logic               is_nan;
    logic               keep_lsb;
    logic [DROP_W:0]    low_sum;
    logic               carry;
    logic [MAG_W-1:0]   mag_r;

    always_comb begin
        sign_b   = word_i[W_IN-1];
        exp_f    = word_i[W_IN-2 -: EXP_W];
        frac_f   = word_i[FRAC_IN-1:0];
        exp_top  = &exp_f;
        is_nan   = exp_top && (|frac_f);
        // nearest-even: add just-under-half plus the kept lsb, watch the carry
        keep_lsb = word_i[DROP_W];
        low_sum  = {1'b0, word_i[DROP_W-1:0]} + HALF_M1 + {{DROP_W{1'b0}}, keep_lsb};
        carry    = (low_sum >= WRAP);
        // small incrementer on exponent+fraction; a fraction carry bumps the exponent
        mag_r    = word_i[W_IN-2:DROP_W] + {{(MAG_W-1){1'b0}}, carry};
        if (is_nan) begin
            half_o = {sign_b, {EXP_W{1'b1}}, 1'b1, frac_f[FRAC_IN-2 -: FRAC_OUT-1]};
            ovf_o  = 1'b0;
        end else begin
            half_o = {sign_b, mag_r};
            ovf_o  = !exp_top && (&mag_r[MAG_W-1 -: EXP_W]);
        end
    end
endmodule

// File: rtl/bf_widen.sv
module bf_widen #(
    parameter int W_IN  = 16,
    parameter int W_OUT = 32
) (
    input  logic [W_IN-1:0]  half_i,
    output logic [W_OUT-1:0] word_o
);
    localparam int PAD_W = W_OUT - W_IN;

    always_comb begin
        word_o = {half_i, {PAD_W{1'b0}}};
    end
endmodule

// File: rtl/bf_stage.sv
module bf_stage
    import bfc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid_i,
    input  logic [WIDE_W-1:0] word_i,
    input  logic              ovf_i,
    input  logic              out_ready_i,
    output logic              in_ready_o,
    output logic              out_valid_o,
    output logic [WIDE_W-1:0] word_o,
    output logic              ovf_o
);
    stage_t st_d, st_q;
    logic   open_w;

    always_comb begin
        open_w = !st_q.vld || out_ready_i;
        st_d   = st_q;
        if (open_w) begin
            st_d.vld = in_valid_i;
            if (in_valid_i) begin
                st_d.word = word_i;
                st_d.ovf  = ovf_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_ready_o  = open_w;
    assign out_valid_o = st_q.vld;
    assign word_o      = st_q.word;
    assign ovf_o       = st_q.ovf;
endmodule

// File: rtl/fp_narrow_widen.sv
module fp_narrow_widen
    import bfc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_mode,
    input  logic [WIDE_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WIDE_W-1:0] out_data,
    output logic              out_ovf
);
    logic [NARROW_W-1:0] narrow_w;
    logic                narrow_ovf;
    logic [WIDE_W-1:0]   widen_w;
    logic [WIDE_W-1:0]   res_d;
    logic                ovf_d;
    conv_mode_e          mode_w;

    bf_narrow #(.W_IN(WIDE_W), .W_OUT(NARROW_W), .EXP_W(EXP_W)) u_narrow (
        .word_i (in_data),
        .half_o (narrow_w),
        .ovf_o  (narrow_ovf)
    );

    bf_widen #(.W_IN(NARROW_W), .W_OUT(WIDE_W)) u_widen (
        .half_i (in_data[NARROW_W-1:0]),
        .word_o (widen_w)
    );

    always_comb begin
        mode_w = conv_mode_e'(in_mode);
        if (mode_w == MODE_WIDEN) begin
            res_d = widen_w;
            ovf_d = 1'b0;
        end else begin
            res_d = {{DROP_W{1'b0}}, narrow_w};
            ovf_d = narrow_ovf;
        end
    end

    bf_stage u_stage (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid_i  (in_valid),
        .word_i      (res_d),
        .ovf_i       (ovf_d),
        .out_ready_i (out_ready),
        .in_ready_o  (in_ready),
        .out_valid_o (out_valid),
        .word_o      (out_data),
        .ovf_o       (out_ovf)
    );
endmodule

// File: rtl/bf_conv_chk.sv
module bf_conv_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_ready,
    input logic        in_mode,
    input logic [31:0] in_data,
    input logic        out_valid,
    input logic        out_ready,
    input logic [31:0] out_data,
    input logic        out_ovf
);
    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_ovf));

    // R9
    stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);

    // R9
    accept_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);

    // R4
    ovf_is_inf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ovf |-> out_data[14:0] == 15'h7F80 && out_data[31:16] == 16'h0);

    // R8
    widen_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_mode |=> out_data[15:0] == 16'h0 && !out_ovf);

    // R5
    nan_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && !in_mode && in_data[30:23] == 8'hFF && in_data[22:0] != 23'h0
        |=> out_data[14:6] == 9'h1FF && out_data[15] == $past(in_data[31]) && !out_ovf);

    // R10
    narrow_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && !in_mode |=> out_data[31:16] == 16'h0);
endmodule

bind fp_narrow_widen bf_conv_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_mode   (in_mode),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_ovf   (out_ovf)
);

// File: tb/tb_fp_narrow_widen.sv
module tb_fp_narrow_widen;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 50000;
    localparam int N_RANDOM   = 400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        in_mode = 1'b0;
    logic [31:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_data;
    logic        out_ovf;

    typedef struct {
        logic [31:0] data;
        logic        ovf;
        string       tag;
    } exp_t;

    exp_t sb[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   ready_rand = 1'b0;

    fp_narrow_widen dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_mode(in_mode), .in_data(in_data), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_ovf(out_ovf)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // reference: guard/sticky form, kept separate from the design's adder form
    function automatic logic [16:0] ref_narrow(logic [31:0] x);
        logic [7:0]  e;
        logic [22:0] f;
        logic [15:0] r;
        logic        up;
        e = x[30:23];
        f = x[22:0];
        if (e == 8'hFF && f != 0) return {1'b0, x[31], 8'hFF, 1'b1, f[21:16]};
        if (e == 8'hFF)           return {1'b0, x[31], 8'hFF, 7'h0};
        up = f[15] && ((f[14:0] != 0) || f[16]);
        r  = {1'b0, e, f[22:16]} + {15'h0, up};
        return {(r[14:7] == 8'hFF), x[31], r[14:0]};
    endfunction

    task automatic check(bit ok, string tag, logic [32:0] act, logic [32:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    task automatic push_send(bit mode, logic [31:0] x, logic [31:0] ed, bit eo, string tag);
        exp_t e;
        e.data = ed; e.ovf = eo; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        in_valid = 1'b1;
        in_mode  = mode;
        in_data  = x;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
    endtask

    task automatic send_ref(bit mode, logic [31:0] x, string tag);
        logic [16:0] r;
        r = ref_narrow(x);
        if (mode) push_send(mode, x, {x[15:0], 16'h0}, 1'b0, tag);
        else      push_send(mode, x, {16'h0, r[15:0]}, r[16], tag);
    endtask

    // consumer side ready pattern, changed just after the edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            out_ready = ready_rand ? (($urandom % 3) != 0) : 1'b1;
        end
    end

    // monitor / scoreboard
    initial begin
        bit          was_stall = 1'b0;
        logic [32:0] held = '0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (was_stall)
                    check(out_valid && {out_ovf, out_data} == held, "R9 hold",
                          {out_ovf, out_data}, held);
                was_stall = 1'b0;
                if (out_valid && !out_ready) begin
                    check(!in_ready, "R9 in_ready", {32'h0, in_ready}, 33'h0);
                    was_stall = 1'b1;
                    held = {out_ovf, out_data};
                end
                if (out_valid && out_ready) begin
                    if (sb.size() == 0) begin
                        check(1'b0, "R9 extra beat", {out_ovf, out_data}, 33'h0);
                    end else begin
                        exp_t e;
                        e = sb.pop_front();
                        check({out_ovf, out_data} == {e.ovf, e.data}, e.tag,
                              {out_ovf, out_data}, {e.ovf, e.data});
                    end
                end
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        check(1'b0, "watchdog", 33'h0, 33'h1);
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!out_valid && in_ready, "R1 reset", {31'h0, out_valid, in_ready}, 33'h1);
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid && in_ready, "R1 after release", {31'h0, out_valid, in_ready}, 33'h1);

        // R2 rounding cases
        push_send(0, 32'h3F80_7FFF, 32'h0000_3F80, 0, "R2 below half");
        push_send(0, 32'h3F80_8001, 32'h0000_3F81, 0, "R2 above half");
        push_send(0, 32'h3F80_8000, 32'h0000_3F80, 0, "R2 tie even stays");
        push_send(0, 32'h3F81_8000, 32'h0000_3F82, 0, "R2 tie odd up");
        push_send(0, 32'hBF81_8000, 32'h0000_BF82, 0, "R2 negative tie");
        push_send(0, 32'h4049_0000, 32'h0000_4049, 0, "R10 exact zero-extended");
        // R3 carry into exponent
        push_send(0, 32'h3FFF_8000, 32'h0000_4000, 0, "R3 fraction carry");
        // R4 overflow
        push_send(0, 32'h7F7F_8000, 32'h0000_7F80, 1, "R4 positive overflow");
        push_send(0, 32'hFF7F_FFFF, 32'h0000_FF80, 1, "R4 negative overflow");
        push_send(0, 32'h7F7F_7FFF, 32'h0000_7F7F, 0, "R4 max finite no flag");
        // R5 NaN
        push_send(0, 32'h7F80_0001, 32'h0000_7FC0, 0, "R5 low-payload NaN");
        push_send(0, 32'hFFA5_0000, 32'h0000_FFE5, 0, "R5 negative NaN payload");
        push_send(0, 32'h7FFF_FFFF, 32'h0000_7FFF, 0, "R5 NaN no wrap");
        // R6 infinity
        push_send(0, 32'h7F80_0000, 32'h0000_7F80, 0, "R6 +inf");
        push_send(0, 32'hFF80_0000, 32'h0000_FF80, 0, "R6 -inf");
        // R7 subnormals
        push_send(0, 32'h0000_8000, 32'h0000_0000, 0, "R7 tie to zero");
        push_send(0, 32'h0001_8000, 32'h0000_0002, 0, "R7 tie odd up");
        push_send(0, 32'h0000_C000, 32'h0000_0001, 0, "R7 above half");
        push_send(0, 32'h007F_FFFF, 32'h0000_0080, 0, "R7 into normal");
        push_send(0, 32'h8000_0001, 32'h0000_8000, 0, "R7 negative tiny");
        // R8 widening
        push_send(1, 32'hABCD_3F81, 32'h3F81_0000, 0, "R8 upper ignored");
        push_send(1, 32'h0000_7FC1, 32'h7FC1_0000, 0, "R8 NaN kept");
        push_send(1, 32'h1234_FF80, 32'hFF80_0000, 0, "R8 inf no flag");

        // R9 random stream with backpressure, overflow edges mixed in
        ready_rand = 1'b1;
        for (int i = 0; i < N_RANDOM; i++) begin
            logic [31:0] x;
            x = $urandom;
            case ($urandom % 5)
                0: x[30:16] = 15'h7F7F;
                1: x[15:0]  = 16'h8000;
                2: x[30:23] = 8'hFF;
                default: ;
            endcase
            send_ref(bit'($urandom % 2), x, "R9 stream");
            if ($urandom % 4 == 0) begin
                @(negedge clk);
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        for (int k = 0; k < 200 && sb.size() != 0; k++) @(negedge clk);
        check(sb.size() == 0, "R9 all delivered", 33'(sb.size()), 33'h0);
        summary();
        $finish;
    end
endmodule